// File: doc/BRIEF.md
# Three-Wire Clock-Chip Serial Host

This block is the host end of a three-wire serial link to a clock chip. The link consists of an active-low chip enable, a host-driven bit clock, and one data line whose direction the host controls. A simple command port accepts one request at a time. A request can send a byte, receive a byte, or close the transaction. The block turns each request into the matching pin activity.

Several bytes can share one enabled transaction. The enable stays low from the first byte to the close request. Each clock phase, low or high, lasts a parameterised number of system clocks. A received byte is handed back with a one-cycle valid strobe. A busy flag covers each byte in flight, and requests made while it is set are dropped.

Top module: `tw_link_host`

## Requirements
- R1: While no transaction is open (after reset or after a close), link_en_n, link_sclk, link_dout and link_doe are all 1 and busy is 0.
- R2: A send or receive accepted with no transaction open pulls link_en_n low on the first clock edge after acceptance. For a send, link_sclk also goes low on that same edge.
- R3: A send shifts out all eight bits of req_data, most significant first. Each bit is placed on link_dout while link_sclk is low and is held stable while link_sclk is high. The byte gives exactly eight rising clock edges and leaves link_sclk high with link_en_n still low.
- R4: Every low phase and every high phase of link_sclk inside a byte lasts PHASE_CYCLES system clocks. A sent byte therefore keeps busy high for 16*PHASE_CYCLES clocks, and a received byte for 17*PHASE_CYCLES clocks.
- R5: A send accepted between bytes of an open transaction pulls link_sclk low on the first edge after acceptance, with no other gap. link_en_n does not rise between chained bytes.
- R6: On a receive request, link_doe drops to 0 while link_sclk is still high. The clock stays high for one phase before its first low phase.
- R7: A receive gives eight low-then-high clock periods. link_din is sampled in the last system clock of each high phase, most significant bit first. link_doe stays 0 for the whole byte.
- R8: After the eighth received bit, link_doe returns to 1. On that same cycle rx_valid pulses for exactly one clock with the received byte on rx_data.
- R9: A close request (req_op 2'b11) accepted between bytes drives link_en_n high on the next clock, with link_sclk and link_dout high.
- R10: busy rises on the clock after a send or receive is accepted and falls when the byte ends. Requests presented while busy is 1 are ignored entirely.
- R11: req_op encodes 2'b01 = send, 2'b10 = receive, 2'b11 = close. 2'b00 is a no-op that changes no line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when busy is 0 |
| req_op | input | 2 | Request code (see R11) |
| req_data | input | BYTE_BITS | Byte to send |
| busy | output | 1 | Byte in progress |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_data | output | BYTE_BITS | Received byte, valid with rx_valid |
| link_en_n | output | 1 | Chip enable, active low |
| link_sclk | output | 1 | Bit clock to the chip |
| link_dout | output | 1 | Data driven toward the chip |
| link_doe | output | 1 | Data direction: 1 = host drives, 0 = host listens |
| link_din | input | 1 | Data returned by the chip |

## Verification
The assertions assume two things. First, req_valid and req_op are known from reset onward. Second, the chip changes link_din only after a falling clock edge, so the value is settled by the last cycle of the following high phase. The bench meets the first by driving every request on falling system-clock edges. It meets the second with a chip model that updates link_din only on falling edges of link_sclk, and only while the host is listening. The bench also places requests in the middle of a byte to show that they have no effect.

// File: rtl/tw_link_pkg.sv
package tw_link_pkg;

   typedef enum logic [1:0] {
      OP_NONE = 2'b00,
      OP_SEND = 2'b01,
      OP_RECV = 2'b10,
      OP_END  = 2'b11
   } tw_op_e;

   typedef enum logic [2:0] {
      ST_OFF,
      ST_HOLD,
      ST_TX_LO,
      ST_TX_HI,
      ST_RX_TURN,
      ST_RX_LO,
      ST_RX_HI
   } tw_state_e;

endpackage

// File: rtl/tw_phase_timer.sv
module tw_phase_timer #(
   parameter int PHASE_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic phase_end
);
   localparam int CW = $clog2(PHASE_CYCLES + 1);
   localparam logic [CW-1:0] LAST = CW'(PHASE_CYCLES - 1);

   generate
      if (PHASE_CYCLES < 1) begin : g_bad_phase
         $error("tw_phase_timer: PHASE_CYCLES must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!run || phase_end)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + 1'b1;
   end

   assign phase_end = run && (cnt_q == LAST);

   // R4: a phase ends only after the counter has run its full span
   p_phase_span_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run) && !$past(phase_end) && PHASE_CYCLES > 1) |-> (cnt_q != '0));

endmodule

// File: rtl/tw_shift_unit.sv
module tw_shift_unit #(
   parameter int BYTE_BITS = 8,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic [BYTE_BITS-1:0] load_data,
   input  logic                 shift_en,
   input  logic                 shift_in,
   output logic                 out_bit,
   output logic                 last_bit,
   output logic [BYTE_BITS-1:0] data
);
   localparam int BW = $clog2(BYTE_BITS);
   localparam logic [BW-1:0] BLAST = BW'(BYTE_BITS - 1);

   generate
      if (BYTE_BITS < 2) begin : g_bad_width
         $error("tw_shift_unit: BYTE_BITS must be at least 2");
      end
   endgenerate

   logic [BYTE_BITS-1:0] sreg_q;
   logic [BYTE_BITS-1:0] sreg_next;
   logic [BW-1:0]        bcnt_q;

   generate
      if (MSB_FIRST) begin : g_msb
         assign sreg_next = {sreg_q[BYTE_BITS-2:0], shift_in};
         assign out_bit   = sreg_q[BYTE_BITS-1];
      end else begin : g_lsb
         assign sreg_next = {shift_in, sreg_q[BYTE_BITS-1:1]};
         assign out_bit   = sreg_q[0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg_q <= '1;
         bcnt_q <= '0;
      end else if (load) begin
         sreg_q <= load_data;
         bcnt_q <= '0;
      end else if (shift_en) begin
         sreg_q <= sreg_next;
         bcnt_q <= last_bit ? '0 : bcnt_q + 1'b1;
      end
   end

   assign last_bit = (bcnt_q == BLAST);
   assign data     = sreg_q;

   // R3: loading a new byte and shifting never coincide
   p_load_xor_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(load && shift_en));

endmodule

// File: rtl/tw_link_host.sv
module tw_link_host
   import tw_link_pkg::*;
#(
   parameter int PHASE_CYCLES = 4,
   parameter int BYTE_BITS    = 8,
   parameter bit MSB_FIRST    = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  logic [1:0]           req_op,
   input  logic [BYTE_BITS-1:0] req_data,
   output logic                 busy,
   output logic                 rx_valid,
   output logic [BYTE_BITS-1:0] rx_data,
   output logic                 link_en_n,
   output logic                 link_sclk,
   output logic                 link_dout,
   output logic                 link_doe,
   input  logic                 link_din
);
   localparam int LW = $clog2(PHASE_CYCLES + 2) + 1;
   localparam logic [LW-1:0] LMAX = '1;

   generate
      if (PHASE_CYCLES < 1) begin : g_bad_phase
         $error("tw_link_host: PHASE_CYCLES must be at least 1");
      end
   endgenerate

   tw_state_e state_q, state_d;
   tw_op_e    op;
   logic      accept, timed, phase_end, last_bit, out_bit;
   logic      load, shift_en, rx_done;

   assign op     = tw_op_e'(req_op);
   assign busy   = (state_q != ST_OFF) && (state_q != ST_HOLD);
   assign accept = req_valid && !busy;
   assign timed  = busy;
   assign load   = accept && (op == OP_SEND || op == OP_RECV);

   tw_phase_timer #(.PHASE_CYCLES(PHASE_CYCLES)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (timed),
      .phase_end (phase_end)
   );

   assign shift_en = phase_end &&
                     ((state_q == ST_TX_HI && !last_bit) || state_q == ST_RX_HI);
   assign rx_done  = phase_end && (state_q == ST_RX_HI) && last_bit;

   tw_shift_unit #(.BYTE_BITS(BYTE_BITS), .MSB_FIRST(MSB_FIRST)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .load_data (req_data),
      .shift_en  (shift_en),
      .shift_in  (link_din),
      .out_bit   (out_bit),
      .last_bit  (last_bit),
      .data      (rx_data)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_OFF, ST_HOLD: begin
            if (accept) begin
               case (op)
                  OP_SEND: state_d = ST_TX_LO;
                  OP_RECV: state_d = ST_RX_TURN;
                  OP_END:  state_d = ST_OFF;
                  default: state_d = state_q;
               endcase
            end
         end
         ST_TX_LO:   if (phase_end) state_d = ST_TX_HI;
         ST_TX_HI:   if (phase_end) state_d = last_bit ? ST_HOLD : ST_TX_LO;
         ST_RX_TURN: if (phase_end) state_d = ST_RX_LO;
         ST_RX_LO:   if (phase_end) state_d = ST_RX_HI;
         ST_RX_HI:   if (phase_end) state_d = last_bit ? ST_HOLD : ST_RX_LO;
         default:    state_d = ST_OFF;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_OFF;
         rx_valid <= 1'b0;
      end else begin
         state_q  <= state_d;
         rx_valid <= rx_done;
      end
   end

   assign link_en_n = (state_q == ST_OFF);
   assign link_sclk = !((state_q == ST_TX_LO) || (state_q == ST_RX_LO));
   assign link_doe  = !((state_q == ST_RX_TURN) || (state_q == ST_RX_LO) ||
                        (state_q == ST_RX_HI));
   assign link_dout = (state_q == ST_OFF) ? 1'b1 : out_bit;

   // checker-side count of consecutive low clock cycles
   logic [LW-1:0] low_len_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         low_len_q <= '0;
      else if (link_sclk)
         low_len_q <= '0;
      else if (low_len_q != LMAX)
         low_len_q <= low_len_q + 1'b1;
   end

   // R1: a closed link keeps every line high and the block idle
   p_closed_lines_r1: assert property (@(posedge clk) disable iff (!rst_n)
      link_en_n |-> (link_sclk && link_dout && link_doe && !busy));

   // R3: sent data does not move while the clock is high
   p_dout_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!link_en_n && !$past(link_en_n) && link_sclk && $past(link_sclk) &&
       link_doe && $past(link_doe)) |-> $stable(link_dout));

   // R4: each low phase spans exactly PHASE_CYCLES clocks
   p_low_span_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(link_sclk) |-> (low_len_q == LW'(PHASE_CYCLES)));

   // R6: direction turns only while the clock is high
   p_turn_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(link_doe) |-> link_sclk);

   // R8: received-byte strobe lasts one clock and comes with output direction
   p_rx_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);
   p_rx_dir_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> (link_doe && !busy));

   // R10: busy only ever starts from a presented request
   p_busy_from_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(req_valid));

endmodule

// File: tb/sim_tw_link_host.sv
module sim_tw_link_host;
   localparam int P = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [1:0] req_op = 2'b00;
   logic [7:0] req_data = 8'h00;
   logic       busy, rx_valid, link_en_n, link_sclk, link_dout, link_doe;
   logic [7:0] rx_data;
   logic       link_din = 1'b0;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   logic [7:0] cap = 8'h00;
   logic [7:0] slave = 8'h00;
   int tx_edges = 0;
   int en_rises = 0;

   always #4 clk = ~clk;

   tw_link_host #(.PHASE_CYCLES(P), .BYTE_BITS(8), .MSB_FIRST(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_data(req_data), .busy(busy), .rx_valid(rx_valid), .rx_data(rx_data),
      .link_en_n(link_en_n), .link_sclk(link_sclk), .link_dout(link_dout),
      .link_doe(link_doe), .link_din(link_din)
   );

   // chip model: capture host bits on rising edges, present bits after falling edges
   always @(posedge link_sclk)
      if (link_en_n === 1'b0 && link_doe === 1'b1) begin
         cap = {cap[6:0], link_dout};
         tx_edges++;
      end
   always @(negedge link_sclk)
      if (link_en_n === 1'b0 && link_doe === 1'b0) begin
         link_din = slave[7];
         slave = {slave[6:0], 1'b0};
      end
   always @(posedge link_en_n) en_rises++;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic issue(input logic [1:0] op, input logic [7:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_op = op; req_data = d;
      @(negedge clk);
      req_valid = 1'b0; req_op = 2'b00;
   endtask

   task automatic wait_done(output int cyc, output bit doe_low);
      cyc = 0; doe_low = 1'b1;
      while (busy) begin
         if (link_doe) doe_low = 1'b0;
         @(negedge clk);
         cyc++;
      end
   endtask

   task automatic do_send(input logic [7:0] d);
      int cyc; bit dl;
      cap = 8'h00; tx_edges = 0;
      issue(2'b01, d);
      chk(!link_sclk && !link_en_n && link_doe, "R2 R5 clock/enable low after send", {link_en_n, link_sclk}, 0);
      wait_done(cyc, dl);
      chk(cyc == 16*P, "R4 send length", cyc, 16*P);
      chk(cap == d, "R3 sent byte", cap, d);
      chk(tx_edges == 8 && link_sclk && !link_en_n, "R3 edges/clock high", tx_edges, 8);
   endtask

   task automatic do_recv(input logic [7:0] d);
      int cyc; bit dl;
      slave = d;
      issue(2'b10, 8'h00);
      chk(link_sclk && !link_doe && !link_en_n, "R6 turn with clock high", {link_sclk, link_doe}, 2'b10);
      wait_done(cyc, dl);
      chk(cyc == 17*P, "R4 receive length", cyc, 17*P);
      chk(dl, "R7 direction held input", dl, 1);
      chk(rx_valid && rx_data == d, "R8 R7 received byte", rx_data, d);
      chk(link_doe, "R8 direction back to output", link_doe, 1);
      @(negedge clk);
      chk(!rx_valid, "R8 strobe one cycle", rx_valid, 0);
   endtask

   task automatic do_close();
      issue(2'b11, 8'h00);
      chk(link_en_n && link_sclk && link_dout && link_doe && !busy, "R9 close lines",
          {link_en_n, link_sclk, link_dout, link_doe, busy}, 5'b11110);
   endtask

   // {receive, data, close afterwards}
   localparam logic [9:0] VEC [0:6] = '{
      {1'b0, 8'hA5, 1'b0},
      {1'b1, 8'h3C, 1'b0},
      {1'b1, 8'hC3, 1'b1},
      {1'b1, 8'h81, 1'b0},
      {1'b0, 8'h7E, 1'b0},
      {1'b0, 8'h00, 1'b1},
      {1'b0, 8'hFF, 1'b1}
   };

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      int base, closes, n;
      repeat (3) @(negedge clk);
      chk(link_en_n && link_sclk && link_dout && link_doe && !busy && !rx_valid,
          "R1 lines in reset", {link_en_n, link_sclk, link_dout, link_doe}, 4'hF);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(link_en_n && link_sclk && link_dout && link_doe && !busy,
          "R1 lines after reset", {link_en_n, link_sclk, link_dout, link_doe}, 4'hF);

      // R11: no-op code leaves a closed link untouched
      issue(2'b00, 8'h55);
      repeat (P) @(negedge clk);
      chk(link_en_n && !busy && link_sclk, "R11 no-op while closed", link_en_n, 1);

      // table walk
      base = en_rises; closes = 0;
      foreach (VEC[i]) begin
         if (VEC[i][9]) do_recv(VEC[i][8:1]);
         else           do_send(VEC[i][8:1]);
         if (VEC[i][0]) begin do_close(); closes++; end
      end
      chk(en_rises - base == closes, "R5 enable stays low between chained bytes", en_rises - base, closes);

      // R4 phase widths and R2 start from closed
      cap = 8'h00; tx_edges = 0;
      issue(2'b01, 8'h96);
      n = 0;
      while (!link_sclk) begin n++; @(negedge clk); end
      chk(n == P, "R4 low phase width", n, P);
      n = 0;
      while (link_sclk) begin n++; @(negedge clk); end
      chk(n == P, "R4 high phase width", n, P);
      while (busy) @(negedge clk);
      chk(cap == 8'h96, "R3 byte after phase probe", cap, 8'h96);

      // R11: no-op between bytes keeps the transaction open and quiet
      issue(2'b00, 8'h00);
      repeat (P) @(negedge clk);
      chk(!link_en_n && link_sclk && !busy, "R11 no-op while open", {link_en_n, busy}, 0);

      // R10: requests during a byte are dropped
      cap = 8'h00; tx_edges = 0;
      issue(2'b01, 8'h5A);
      repeat (3) @(negedge clk);
      chk(busy, "R10 busy during byte", busy, 1);
      issue(2'b01, 8'h0F);
      issue(2'b11, 8'h00);
      chk(!link_en_n, "R10 close ignored while busy", link_en_n, 0);
      issue(2'b10, 8'h00);
      while (busy) @(negedge clk);
      chk(cap == 8'h5A && tx_edges == 8, "R10 byte unaffected", cap, 8'h5A);
      repeat (3*P) @(negedge clk);
      chk(!busy && link_sclk && link_doe && tx_edges == 8, "R10 nothing queued", tx_edges, 8);
      do_close();

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule